// File: doc/BRIEF.md
# Byte-Lane Error-Correcting Word Memory

This block is a synchronous single-port word memory, 16 bits wide. The word is split into two independent 8-bit byte lanes. Each lane keeps its own 4 check bits next to its data byte, so a stored lane is a 12-bit single-error-correcting codeword. A write refreshes only the lanes whose active-low lane enable is asserted. Each lane it writes gets newly computed check bits. A partial-word write therefore never has to read the other lane back.

On a read, every enabled lane is decoded. A single flipped bit anywhere in the codeword is repaired, and that lane's corrected flag pulses alongside the data. A syndrome that points past the end of the codeword raises an uncorrectable flag, and the data bits are passed on as stored. Results appear one clock after the request. A test-only injection port flips chosen codeword bits in place, so a bench can show that the repair works.

The depth is a parameter. The default of 10 address bits keeps elaboration small. A full-size instance sets the address width to 18, which gives 256K words.

Top module: `ecc_byte_mem`

## Requirements
- R1: Data bits 7:0 belong to the lower lane, gated by `lane_n_i[0]` low; bits 15:8 belong to the upper lane, gated by `lane_n_i[1]` low; either lane or both may be accessed in one cycle.
- R2: A write (`sel_i`=1, `wr_i`=1) stores only enabled lanes; a disabled lane keeps its data and its check bits.
- R3: A read (`sel_i`=1, `wr_i`=0) returns the addressed lanes on the outputs exactly one clock edge after the request; back-to-back reads return back-to-back results.
- R4: In any cycle after a clock edge that did not read a lane, that lane's data slice is zero, and its valid, corrected and uncorrectable bits are low. This covers a disabled lane, a write, an idle cycle and an injection.
- R5: Each lane is stored as a 12-bit codeword, bit i holding position i+1. Check bits sit at positions 1, 2, 4 and 8. Data bits d0..d7 sit at positions 3, 5, 6, 7, 9, 10, 11 and 12. Check bit at position p is the XOR of all data positions whose index has bit p set. A clean lane reads back with no flags.
- R6: On a read, the syndrome is the XOR of the position numbers of all set codeword bits. If it lies in 1..12, that bit is inverted before the data is extracted, and the lane's corrected flag is high for that one result cycle. This applies to check-bit positions too.
- R7: A syndrome of 13, 14 or 15 raises the lane's uncorrectable flag, leaves corrected low, and returns the data bits exactly as stored.
- R8: With `inj_en_i`=1, the 12-bit `inj_mask_i` is XORed into the stored codeword of lane `inj_lane_i` (0 lower, 1 upper) at `addr_i`. Any read or write requested in that cycle is ignored.
- R9: While `rst_n` is low at a clock edge, all outputs go to zero.
- R10: Writing a lane again after an injected error stores a fresh codeword, and it reads back clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_i | input | 1 | Access request |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 16 | Write data |
| lane_n_i | input | 2 | Active-low lane enables, bit 0 lower, bit 1 upper |
| inj_en_i | input | 1 | Test-only error injection strobe |
| inj_lane_i | input | 1 | Lane that receives the injection |
| inj_mask_i | input | 12 | Codeword bits to flip |
| rdata_o | output | 16 | Read data, zero on lanes not read |
| rvalid_o | output | 2 | Per-lane read valid |
| corr_o | output | 2 | Per-lane single-error corrected |
| uncorr_o | output | 2 | Per-lane uncorrectable syndrome |

## Verification
The bench injects a single flip at each of the twelve codeword positions, in both lanes and at check-bit positions as well as data positions. A decoder with a wrong position map would return damaged data, or raise the flag on the wrong lane. A double flip whose syndrome is 13 must come back raw with only the uncorrectable flag set; a design that tries to index past the codeword would corrupt an unrelated bit. Partial writes followed by full reads would expose a design that re-encodes the untouched lane. A write issued during an injection cycle would show up if the design let access through while injecting.

// File: rtl/ecc_lane_pkg.sv
// Shared constants and codeword functions for the byte-lane ECC memory.
// Assumes a Hamming(12,8) layout: codeword bit i carries position i+1,
// check bits at positions 1,2,4,8, data in ascending order elsewhere.
package ecc_lane_pkg;
    localparam int LANE_W    = 8;
    localparam int CHK_W     = 4;
    localparam int CW_W      = LANE_W + CHK_W;
    localparam int NUM_LANES = 2;

    typedef logic [CW_W-1:0]   cw_t;
    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [CHK_W-1:0]  syn_t;

    // Build a codeword: place data, then fill each check position.
    function automatic cw_t cw_encode(input lane_t d);
        cw_t c;
        logic x;
        c = '0;
        c[2]  = d[0];
        c[4]  = d[1];
        c[5]  = d[2];
        c[6]  = d[3];
        c[8]  = d[4];
        c[9]  = d[5];
        c[10] = d[6];
        c[11] = d[7];
        for (int p = 0; p < CHK_W; p++) begin
            x = 1'b0;
            for (int i = 0; i < CW_W; i++) begin
                if ((((i + 1) >> p) & 1) == 1) x = x ^ c[i];
            end
            c[(1 << p) - 1] = x;
        end
        return c;
    endfunction

    // XOR of the positions of all set bits.
    function automatic syn_t cw_syndrome(input cw_t c);
        syn_t s;
        s = '0;
        for (int i = 0; i < CW_W; i++) begin
            if (c[i]) s = s ^ syn_t'(i + 1);
        end
        return s;
    endfunction

    // Pull the data byte out of the non-check positions.
    function automatic lane_t cw_data(input cw_t c);
        return {c[11], c[10], c[9], c[8], c[6], c[5], c[4], c[2]};
    endfunction
endpackage

// File: rtl/lane_decoder.sv
// Combinational syndrome decode and single-bit repair for one lane.
// Assumes the codeword layout of ecc_lane_pkg. A syndrome past the last
// position is flagged and the stored data passes through untouched.
module lane_decoder
    import ecc_lane_pkg::*;
(
    input  cw_t   cw_i,
    output lane_t data_o,
    output logic  corr_o,
    output logic  uncorr_o
);
    syn_t syn;
    cw_t  fixed;

    // Classify the syndrome and repair the pointed-at bit when in range.
    always_comb begin
        syn      = cw_syndrome(cw_i);
        fixed    = cw_i;
        corr_o   = 1'b0;
        uncorr_o = 1'b0;
        if (syn != '0) begin
            if (int'(syn) <= CW_W) begin
                fixed[syn - syn_t'(1)] = ~cw_i[syn - syn_t'(1)];
                corr_o = 1'b1;
            end else begin
                uncorr_o = 1'b1;
            end
        end
        data_o = cw_data(fixed);
    end
endmodule

// File: rtl/lane_slice.sv
// One byte lane: codeword storage, encode on write, in-place injection,
// decode on read with a registered one-cycle result.
// Assumes wr_en, rd_en and inj_en are already qualified by the top.
module lane_slice
    import ecc_lane_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              inj_en,
    input  logic [ADDR_W-1:0] addr,
    input  lane_t             wdata,
    input  cw_t               inj_mask,
    output lane_t             rdata,
    output logic              rvalid,
    output logic              corr,
    output logic              uncorr
);
    localparam int DEPTH = 1 << ADDR_W;

    cw_t   store [DEPTH];
    lane_t dec_data;
    logic  dec_corr;
    logic  dec_uncorr;

    // Storage update: injection flips bits, a write stores a fresh codeword.
    always_ff @(posedge clk) begin
        if (inj_en)     store[addr] <= store[addr] ^ inj_mask;
        else if (wr_en) store[addr] <= cw_encode(wdata);
    end

    lane_decoder i_dec (
        .cw_i     (store[addr]),
        .data_o   (dec_data),
        .corr_o   (dec_corr),
        .uncorr_o (dec_uncorr)
    );

    // Result register: decoded lane on a read, all zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
            corr   <= 1'b0;
            uncorr <= 1'b0;
        end else if (rd_en) begin
            rdata  <= dec_data;
            rvalid <= 1'b1;
            corr   <= dec_corr;
            uncorr <= dec_uncorr;
        end else begin
            rdata  <= '0;
            rvalid <= 1'b0;
            corr   <= 1'b0;
            uncorr <= 1'b0;
        end
    end

    AST_READ_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid); // R3
    AST_NO_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rvalid && rdata == '0 && !corr && !uncorr)); // R4
    AST_FLAGS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        !(corr && uncorr)); // R7
    AST_FRESH_WRITE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(wr_en) && addr == $past(addr))
        |=> (!corr && !uncorr && rdata == $past(wdata, 2))); // R5
endmodule

// File: rtl/ecc_byte_mem.sv
// Top of the byte-lane ECC memory: qualifies the access per lane from the
// active-low lane enables and the injection strobe, then drives one
// lane_slice per byte lane. Injection takes the cycle: no access then.
module ecc_byte_mem
    import ecc_lane_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sel_i,
    input  logic                         wr_i,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [NUM_LANES*LANE_W-1:0]  wdata_i,
    input  logic [NUM_LANES-1:0]         lane_n_i,
    input  logic                         inj_en_i,
    input  logic                         inj_lane_i,
    input  logic [CW_W-1:0]              inj_mask_i,
    output logic [NUM_LANES*LANE_W-1:0]  rdata_o,
    output logic [NUM_LANES-1:0]         rvalid_o,
    output logic [NUM_LANES-1:0]         corr_o,
    output logic [NUM_LANES-1:0]         uncorr_o
);
    localparam int LANE_IDX_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

    logic [NUM_LANES-1:0] lane_acc;
    logic [NUM_LANES-1:0] lane_wr;
    logic [NUM_LANES-1:0] lane_rd;
    logic [NUM_LANES-1:0] lane_inj;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        // Per-lane access qualification.
        always_comb begin
            lane_acc[g] = sel_i && !inj_en_i && !lane_n_i[g];
            lane_wr[g]  = lane_acc[g] && wr_i;
            lane_rd[g]  = lane_acc[g] && !wr_i;
            lane_inj[g] = inj_en_i && (LANE_IDX_W'(inj_lane_i) == LANE_IDX_W'(g));
        end

        lane_slice #(.ADDR_W(ADDR_W)) i_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (lane_wr[g]),
            .rd_en    (lane_rd[g]),
            .inj_en   (lane_inj[g]),
            .addr     (addr_i),
            .wdata    (wdata_i[g*LANE_W +: LANE_W]),
            .inj_mask (inj_mask_i),
            .rdata    (rdata_o[g*LANE_W +: LANE_W]),
            .rvalid   (rvalid_o[g]),
            .corr     (corr_o[g]),
            .uncorr   (uncorr_o[g])
        );
    end

    AST_INJECT_BLOCKS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        inj_en_i |=> (rvalid_o == '0)); // R8
    AST_DISABLED_LANE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && !wr_i && !inj_en_i) |=> (rvalid_o == ~$past(lane_n_i))); // R1
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (rvalid_o == '0 && rdata_o == '0 && corr_o == '0 && uncorr_o == '0)); // R9
endmodule

// File: tb/test_ecc_byte_mem.sv
`timescale 1ns/1ps
module test_ecc_byte_mem;
    localparam int AW = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic [1:0]  lane_n_i = 2'b11;
    logic        inj_en_i = 1'b0;
    logic        inj_lane_i = 1'b0;
    logic [11:0] inj_mask_i = '0;
    logic [15:0] rdata_o;
    logic [1:0]  rvalid_o, corr_o, uncorr_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // reference model: one codeword per lane per word
    logic [11:0] ref_mem [2][1 << AW];
    logic [15:0] e_data;
    logic [1:0]  e_valid, e_corr, e_uncorr;

    always #2 clk = ~clk;

    ecc_byte_mem #(.ADDR_W(AW)) i_ecc_byte_mem (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .wr_i(wr_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .lane_n_i(lane_n_i), .inj_en_i(inj_en_i),
        .inj_lane_i(inj_lane_i), .inj_mask_i(inj_mask_i), .rdata_o(rdata_o),
        .rvalid_o(rvalid_o), .corr_o(corr_o), .uncorr_o(uncorr_o));

    function automatic bit is_chk(input int pos);
        return (pos == 1) || (pos == 2) || (pos == 4) || (pos == 8);
    endfunction

    // Behavioural encoder: walk positions, fill data, then parities.
    function automatic logic [11:0] m_enc(input logic [7:0] d);
        logic [11:0] c = '0;
        int k = 0;
        for (int pos = 1; pos <= 12; pos++)
            if (!is_chk(pos)) begin c[pos-1] = d[k]; k++; end
        for (int pb = 1; pb <= 8; pb = pb * 2) begin
            bit par = 0;
            for (int pos = 1; pos <= 12; pos++)
                if (!is_chk(pos) && (pos & pb) != 0) par ^= c[pos-1];
            c[pb-1] = par;
        end
        return c;
    endfunction

    function automatic logic [7:0] m_data(input logic [11:0] c);
        logic [7:0] d = '0;
        int k = 0;
        for (int pos = 1; pos <= 12; pos++)
            if (!is_chk(pos)) begin d[k] = c[pos-1]; k++; end
        return d;
    endfunction

    task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        check(tag, "rdata", rdata_o, e_data);
        check(tag, "rvalid", {14'd0, rvalid_o}, {14'd0, e_valid});
        check(tag, "corr", {14'd0, corr_o}, {14'd0, e_corr});
        check(tag, "uncorr", {14'd0, uncorr_o}, {14'd0, e_uncorr});
    endtask

    // One cycle: drive at the falling edge, predict, compare at next falling edge.
    task automatic cyc(input string tag, input bit s, input bit w, input int a,
                       input logic [15:0] d, input logic [1:0] ln,
                       input bit ie, input bit il, input logic [11:0] im);
        sel_i = s; wr_i = w; addr_i = AW'(a); wdata_i = d; lane_n_i = ln;
        inj_en_i = ie; inj_lane_i = il; inj_mask_i = im;
        e_data = '0; e_valid = '0; e_corr = '0; e_uncorr = '0;
        for (int g = 0; g < 2; g++) begin
            if (s && !w && !ie && !ln[g]) begin
                logic [11:0] c = ref_mem[g][a];
                int syn = 0;
                for (int pos = 1; pos <= 12; pos++) if (c[pos-1]) syn ^= pos;
                if (syn >= 1 && syn <= 12) begin c[syn-1] = ~c[syn-1]; e_corr[g] = 1; end
                else if (syn > 12) e_uncorr[g] = 1;
                e_data[g*8 +: 8] = m_data(c);
                e_valid[g] = 1;
            end
        end
        if (ie) ref_mem[il][a] = ref_mem[il][a] ^ im;
        else if (s && w)
            for (int g = 0; g < 2; g++) if (!ln[g]) ref_mem[g][a] = m_enc(d[g*8 +: 8]);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic wr(input string tag, input int a, input logic [15:0] d, input logic [1:0] ln);
        cyc(tag, 1, 1, a, d, ln, 0, 0, '0);
    endtask
    task automatic rd(input string tag, input int a, input logic [1:0] ln);
        cyc(tag, 1, 0, a, 16'h0, ln, 0, 0, '0);
    endtask
    task automatic inj(input string tag, input int a, input bit l, input logic [11:0] m);
        cyc(tag, 0, 0, a, 16'h0, 2'b11, 1, l, m);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R9: outputs zero under reset
        repeat (3) @(negedge clk);
        e_data = '0; e_valid = '0; e_corr = '0; e_uncorr = '0;
        compare("R9");
        rst_n = 1'b1;

        // R1 R3 R5: full write then full read
        wr("R5", 5, 16'hA53C, 2'b00);
        rd("R3", 5, 2'b00);
        // R2: lower-only then upper-only writes keep the other lane
        wr("R2", 5, 16'h11FF, 2'b10);
        rd("R2", 5, 2'b00);
        wr("R2", 5, 16'h7788, 2'b01);
        rd("R2", 5, 2'b00);
        // R1 R4: single-lane reads and no-lane read
        rd("R1", 5, 2'b10);
        rd("R1", 5, 2'b01);
        rd("R4", 5, 2'b11);
        cyc("R4", 0, 0, 5, 16'h0, 2'b00, 0, 0, '0);
        // R2: write with both lanes disabled changes nothing
        wr("R2", 5, 16'h0000, 2'b11);
        rd("R2", 5, 2'b00);

        // R6 R8: single flip at every position in both lanes
        for (int pos = 1; pos <= 12; pos++) begin
            for (int l = 0; l < 2; l++) begin
                int a = 16 + pos * 2 + l;
                wr("R6", a, 16'(pos * 16'h1357 + l * 16'h0F0F), 2'b00);
                inj("R8", a, l[0], 12'(1 << (pos - 1)));
                rd("R6", a, 2'b00);
            end
        end

        // R7: flips at positions 12 and 1 give syndrome 13
        wr("R7", 60, 16'h5A96, 2'b00);
        inj("R7", 60, 0, 12'h801);
        rd("R7", 60, 2'b00);
        // R7: positions 12 and 3 give syndrome 15 in upper lane
        inj("R7", 60, 1, 12'h804);
        rd("R7", 60, 2'b00);
        // R10: rewrite clears both
        wr("R10", 60, 16'h5A96, 2'b00);
        rd("R10", 60, 2'b00);

        // R8: write requested during injection is ignored
        wr("R8", 70, 16'hC0DE, 2'b00);
        cyc("R8", 1, 1, 70, 16'hFFFF, 2'b00, 1, 1, 12'h010);
        rd("R8", 70, 2'b00);
        // R8: read requested during injection gives nothing
        cyc("R8", 1, 0, 70, 16'h0, 2'b00, 1, 0, 12'h020);
        rd("R8", 70, 2'b00);

        // R3: back-to-back reads of different words
        wr("R3", 80, 16'h1234, 2'b00);
        wr("R3", 81, 16'hFEDC, 2'b00);
        rd("R3", 80, 2'b00);
        rd("R3", 81, 2'b00);
        rd("R3", 80, 2'b00);

        // R1 R2 R6: mixed random traffic on pre-filled words
        for (int a = 100; a < 132; a++) wr("R2", a, 16'(a * 16'h9E37), 2'b00);
        for (int n = 0; n < 400; n++) begin
            int a = 100 + int'($urandom_range(31));
            int op = int'($urandom_range(3));
            logic [1:0] ln = 2'($urandom_range(3));
            if (op == 0) wr("R2", a, 16'($urandom), ln);
            else if (op == 3) begin
                wr("R10", a, 16'($urandom), 2'b00);
                inj("R6", a, 1'($urandom_range(1)), 12'(1 << $urandom_range(11)));
            end
            else rd("R1", a, ln);
        end

        // R9: reset mid-run clears outputs
        sel_i = 1; wr_i = 0; lane_n_i = 2'b00; rst_n = 1'b0;
        @(negedge clk);
        e_data = '0; e_valid = '0; e_corr = '0; e_uncorr = '0;
        compare("R9");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule